// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes a 64-bit software-generated-interrupt request issued by one CPU and turns it into pending-set strobes for the CPUs it addresses. The request carries a small interrupt ID, a routing-mode bit, three upper affinity bytes and a 16-bit list of level-0 targets. Each CPU's affinity is supplied as a packed table input, so the block needs no knowledge of how CPUs are numbered beyond their index.

After a request is accepted the block walks the CPUs one per clock, lowest index first. In broadcast mode every CPU other than the requester is signalled. In targeted mode a CPU is signalled when its upper affinity bytes equal the request's and its level-0 value selects a set bit of a working copy of the target list; that bit is then cleared, and the walk stops as soon as the copy is empty. A done pulse closes each request, and a kick pulse accompanies it when at least one CPU was signalled, so downstream logic can re-evaluate its pending state once per request.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt ID is taken from request bits [27:24] and is presented on pendId whenever a pendSet bit is high; the routing mode is bit 40.
- R2: With bit 40 set, every CPU except the one named on reqCpu receives exactly one pendSet pulse, and the walk covers all NUM_CPUS CPUs.
- R3: With bit 40 clear, a CPU is selected only if its affinity bytes 3, 2, 1 (table bits [31:24], [23:16], [15:8] of its 32-bit entry) equal request bits [55:48], [39:32], [23:16] and its level-0 byte (entry bits [7:0]) is below 16 and indexes a set bit of the target list in request bits [15:0].
- R4: CPUs are examined one per cycle in ascending index; CPU k is examined in the k-th cycle after acceptance (counting from 0), so pendSet is at most one-hot and only bit k can be high in that cycle.
- R5: In targeted mode each selected CPU's level-0 bit is removed from the working list, and the walk ends after the CPU whose selection empties the list.
- R6: kick pulses together with done only when at least one CPU was signalled; a request that signals no CPU leaves kick low.
- R7: A targeted request with an empty target list never raises busy, signals no CPU, and pulses done (with kick low) in the cycle after acceptance.
- R8: busy is high for exactly the walk cycles; done is a single-cycle pulse in the cycle after the last examined CPU, with busy low.
- R9: reqValid is ignored while busy is high: the running walk's results are unaffected and no second walk follows.
- R10: After reset busy, done, kick and pendSet are all low.
- R11: A request presented in the same cycle as done is accepted, and its walk starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; accepted when busy is low |
| reqWord | input | 64 | Request word (fields per R1, R3) |
| reqCpu | input | CPU_W | Index of the requesting CPU |
| cpuAffinity | input | NUM_CPUS*32 | Affinity table, entry k at bits [32k+31:32k] |
| pendSet | output | NUM_CPUS | Per-CPU pending-set pulse |
| pendId | output | 4 | Interrupt ID for pendSet |
| kick | output | 1 | Update pulse with done when any CPU was signalled |
| done | output | 1 | Request completion pulse |
| busy | output | 1 | Walk in progress |

## Verification
Two functions share a cycle: the done and kick pulses that close one request, and the acceptance of the next request, because busy has already fallen when done is high. The bench provokes this by presenting a second request in exactly the done cycle of a targeted request, then judges that the first request's kick is correct and that the second walk's pulses start in the following cycle with its own ID and the correct CPU pattern. A related overlap, a fresh request arriving mid-walk, is judged by confirming the walk's pattern is unchanged and that busy stays low after done.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int AFF_W = 32;
  localparam int ID_W = 4;
  localparam int LIST_W = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a non-empty request
    logic step;    // examine the CPU at the walk index
    logic finish;  // this step is the last one
  } walkCtl_t;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     emptyTarget,
  input  logic     lastStep,
  output walkCtl_t ctl,
  output logic     busy,
  output logic     done
);
  typedef enum logic {IDLE, WALK} state_t;
  state_t state;
  logic accept;

  assign accept     = reqValid && (state == IDLE);
  assign ctl.load   = accept && !emptyTarget;
  assign ctl.step   = (state == WALK);
  assign ctl.finish = (state == WALK) && lastStep;
  assign busy       = (state == WALK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      done <= (accept && emptyTarget) || ctl.finish;
      if (ctl.load)        state <= WALK;
      else if (ctl.finish) state <= IDLE;
    end
  end
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  walkCtl_t                  ctl,
  input  logic [63:0]               reqWord,
  input  logic [CPU_W-1:0]          reqCpu,
  input  logic [NUM_CPUS*AFF_W-1:0] cpuAffinity,
  output logic                      emptyTarget,
  output logic                      lastStep,
  output logic [NUM_CPUS-1:0]       pendSet,
  output logic [ID_W-1:0]           pendId,
  output logic                      kick
);
  localparam logic [CPU_W-1:0] LAST_IDX = CPU_W'(NUM_CPUS - 1);

  logic              bcastQ;
  logic [23:0]       affUpQ;
  logic [LIST_W-1:0] maskQ, maskNext;
  logic [CPU_W-1:0]  reqCpuQ, idxQ;
  logic              anyHitQ;
  logic [AFF_W-1:0]  curAff;
  logic              hit;

  assign emptyTarget = !reqWord[40] && (reqWord[15:0] == '0);
  assign curAff = cpuAffinity[idxQ*AFF_W +: AFF_W];

  always_comb begin
    if (bcastQ)
      hit = (idxQ != reqCpuQ);
    else
      hit = (curAff[31:8] == affUpQ) && (curAff[7:4] == 4'd0) && maskQ[curAff[3:0]];
    maskNext = maskQ;
    if (hit && !bcastQ) maskNext[curAff[3:0]] = 1'b0;
    lastStep = (idxQ == LAST_IDX) || (!bcastQ && (maskNext == '0));
  end

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_pend
    assign pendSet[g] = ctl.step && hit && (idxQ == CPU_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendId  <= '0;
      bcastQ  <= 1'b0;
      affUpQ  <= '0;
      maskQ   <= '0;
      reqCpuQ <= '0;
      idxQ    <= '0;
      anyHitQ <= 1'b0;
      kick    <= 1'b0;
    end else begin
      kick <= ctl.finish && (anyHitQ || hit);
      if (ctl.load) begin
        pendId  <= reqWord[27:24];
        bcastQ  <= reqWord[40];
        affUpQ  <= {reqWord[55:48], reqWord[39:32], reqWord[23:16]};
        maskQ   <= reqWord[15:0];
        reqCpuQ <= reqCpu;
        idxQ    <= '0;
        anyHitQ <= 1'b0;
      end else if (ctl.step) begin
        maskQ   <= maskNext;
        idxQ    <= idxQ + 1'b1;
        anyHitQ <= anyHitQ || hit;
      end
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reqValid,
  input  logic [63:0]               reqWord,
  input  logic [CPU_W-1:0]          reqCpu,
  input  logic [NUM_CPUS*AFF_W-1:0] cpuAffinity,
  output logic [NUM_CPUS-1:0]       pendSet,
  output logic [ID_W-1:0]           pendId,
  output logic                      kick,
  output logic                      done,
  output logic                      busy
);
  walkCtl_t ctl;
  logic emptyTarget, lastStep;

  sgi_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .emptyTarget(emptyTarget), .lastStep(lastStep),
    .ctl(ctl), .busy(busy), .done(done)
  );

  sgi_datapath #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqWord(reqWord),
    .reqCpu(reqCpu), .cpuAffinity(cpuAffinity),
    .emptyTarget(emptyTarget), .lastStep(lastStep),
    .pendSet(pendSet), .pendId(pendId), .kick(kick)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPUS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic [NUM_CPUS-1:0] pendSet,
  input logic [3:0]          pendId,
  input logic                kick,
  input logic                done,
  input logic                busy
);
  // R4
  pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pendSet));

  // R8
  pend_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendSet != '0) |-> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  kick_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> done);

  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pendId));

  // R11
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid));

  // R8
  walk_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) i_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .pendSet(pendSet),
  .pendId(pendId), .kick(kick), .done(done), .busy(busy)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
  localparam int N = 8;
  localparam int CW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [63:0] reqWord = '0;
  logic [CW-1:0] reqCpu = '0;
  logic [N*32-1:0] cpuAffinity;
  logic [N-1:0] pendSet;
  logic [3:0] pendId;
  logic kick, done, busy;

  int checks = 0;
  int fails = 0;
  logic [31:0] affTab [N];

  sgi_dispatch #(.NUM_CPUS(N)) i_sgi_dispatch (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWord(reqWord),
    .reqCpu(reqCpu), .cpuAffinity(cpuAffinity), .pendSet(pendSet),
    .pendId(pendId), .kick(kick), .done(done), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) cpuAffinity[i*32 +: 32] = affTab[i];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(input logic [3:0] id, input bit bc,
      input logic [7:0] a3, input logic [7:0] a2, input logic [7:0] a1,
      input logic [15:0] list);
    logic [63:0] w = '0;
    w[15:0] = list; w[23:16] = a1; w[27:24] = id;
    w[39:32] = a2; w[40] = bc; w[55:48] = a3;
    return w;
  endfunction

  // independent reference from the requirements
  task automatic model(input logic [63:0] w, input int cpu,
      output logic [N-1:0] mask, output int steps, output bit kk);
    logic [15:0] wl = w[15:0];
    mask = '0; steps = 0;
    if (!w[40] && wl == 0) begin kk = 0; return; end
    for (int i = 0; i < N; i++) begin
      bit sel;
      if (w[40]) sel = (i != cpu);
      else sel = affTab[i][31:24] == w[55:48] && affTab[i][23:16] == w[39:32] &&
                 affTab[i][15:8] == w[23:16] && affTab[i][7:0] < 16 &&
                 wl[affTab[i][3:0]];
      if (sel) begin
        mask[i] = 1'b1;
        if (!w[40]) wl[affTab[i][3:0]] = 1'b0;
      end
      steps = i + 1;
      if (!w[40] && wl == 0) break;
    end
    kk = (mask != 0);
  endtask

  // caller has driven the request; observes the walk until done.
  // Optionally injects a request mid-walk or chains one in the done cycle.
  task automatic walk(input string tag, input logic [63:0] w, input int cpu,
      input bit inject, input bit chain, input logic [63:0] nw, input int ncpu);
    logic [N-1:0] expMask, seen;
    int expSteps, steps;
    bit expKick, sawDone;
    model(w, cpu, expMask, expSteps, expKick);
    seen = '0; steps = 0; sawDone = 0;
    for (int t = 0; t < 40 && !sawDone; t++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (done) begin
        sawDone = 1;
        check(busy == 0, {tag, " R8 busy low at done"}, busy, 0);
        check(kick == expKick, {tag, " R6 kick"}, kick, expKick);
        if (chain) begin reqValid = 1'b1; reqWord = nw; reqCpu = CW'(ncpu); end
      end else begin
        if (busy) steps++;
        if (pendSet != 0) begin
          check(pendSet == (N'(1) << (steps - 1)), {tag, " R4 slot order"}, pendSet, N'(1) << (steps - 1));
          check(pendId == w[27:24], {tag, " R1 pendId"}, pendId, w[27:24]);
        end
        seen |= pendSet;
        if (inject && steps == 2) begin
          reqValid = 1'b1;
          reqWord = mkWord(4'hF, 1'b1, 0, 0, 0, 16'hFFFF);
          reqCpu = '0;
        end
      end
    end
    check(sawDone, {tag, " R8 done seen"}, sawDone, 1);
    check(seen == expMask, {tag, " R2/R3 selected CPUs"}, seen, expMask);
    check(steps == expSteps, {tag, " R5 walk length"}, steps, expSteps);
  endtask

  task automatic issue(input logic [63:0] w, input int cpu);
    @(negedge clk);
    reqValid = 1'b1; reqWord = w; reqCpu = CW'(cpu);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0 && kick == 0 && pendSet == 0,
          "R10 reset state", {busy, done, kick, pendSet}, 0);
  endtask

  task automatic t_broadcast;
    logic [63:0] w = mkWord(4'h9, 1'b1, 8'h11, 8'h22, 8'h33, 16'h0);
    issue(w, 3);
    walk("R2 broadcast", w, 3, 0, 0, 0, 0);
  endtask

  task automatic t_early_stop;
    logic [63:0] w = mkWord(4'h5, 1'b0, 0, 0, 0, 16'b1100);
    issue(w, 7);
    walk("R5 early stop", w, 7, 0, 0, 0, 0);
  endtask

  task automatic t_aff_match;
    logic [63:0] w = mkWord(4'hA, 1'b0, 0, 0, 8'd1, 16'h000F);
    issue(w, 0);
    walk("R3 affinity match", w, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_match;
    logic [63:0] w = mkWord(4'h2, 1'b0, 8'h7, 0, 8'd9, 16'hFFFF);
    issue(w, 1);
    walk("R6 no target", w, 1, 0, 0, 0, 0);
  endtask

  task automatic t_empty;
    logic [63:0] w = mkWord(4'h3, 1'b0, 0, 0, 0, 16'h0);
    issue(w, 2);
    @(negedge clk);
    reqValid = 1'b0;
    check(done == 1 && busy == 0 && kick == 0 && pendSet == 0,
          "R7 empty list completes at once", {done, busy, kick, pendSet}, 12'h800 >> 0 == 0 ? 0 : {1'b1, 2'b00, N'(0)});
  endtask

  task automatic t_busy_ignore;
    logic [63:0] w = mkWord(4'h6, 1'b1, 0, 0, 0, 16'h0);
    issue(w, 5);
    walk("R9 busy ignore", w, 5, 1, 0, 0, 0);
    @(negedge clk);
    check(busy == 0 && done == 0, "R9 no second walk", {busy, done}, 0);
  endtask

  task automatic t_chain;
    logic [63:0] w1 = mkWord(4'h1, 1'b0, 0, 0, 0, 16'b0001);
    logic [63:0] w2 = mkWord(4'hC, 1'b1, 0, 0, 0, 16'h0);
    issue(w1, 6);
    walk("R11 first", w1, 6, 0, 1, w2, 0);
    walk("R11 chained", w2, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) affTab[i] = {8'd0, 8'd0, 8'd0, 8'(3 - i)};
    for (int i = 4; i < N; i++) affTab[i] = {8'd0, 8'd0, 8'd1, 8'(i - 4)};
    affTab[7][23:16] = 8'd5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_broadcast();
    t_early_stop();
    t_aff_match();
    t_no_match();
    t_empty();
    t_busy_ignore();
    t_chain();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule